// File: doc/BRIEF.md
# I2C Slave Receiver with Event Flags

This block is the receive side of an I2C target. It watches the open-drain SCL and SDA lines and finds Start, repeated Start and Stop conditions. It matches its own 7-bit address, or a 10-bit address sent as a header byte followed by a low address byte. It acknowledges every byte it accepts and hands data bytes to host software through a small register interface.

Three event flags report progress to software: address matched, receive data available and Stop seen. Each flag can raise a shared interrupt line. While software still owes service on the address flag, or on a full data register when the next byte arrives, the block holds SCL low so the bus master waits. The address and Stop flags clear only through fixed, ordered register-access sequences. A lone access leaves the flag set.

The register file is addressed by a 3-bit offset:

| Offset | Access | Contents |
|---|---|---|
| 0 | read/write | control: bit 0 enable, bit 1 event-interrupt enable, bit 2 10-bit mode |
| 1 | read/write | own address bits 7:0 |
| 2 | read/write | own address bits 9:8, held in bits 1:0 |
| 3 | read | status 1: bit 0 address matched, bit 1 receive data available, bit 2 Stop seen |
| 4 | read | status 2: bit 0 addressed (a match has been seen and no Stop has followed yet) |
| 5 | read | received data byte |

Top module: `i2c_rx_target`

## Requirements
- R1: After reset both pull-low outputs are 0, irq is 0 and status 1 (offset 3) reads 0.
- R2: In 7-bit mode (control bit 2 = 0), a first byte whose bits 7:1 equal own address bits 6:0 and whose bit 0 is 0 is acknowledged, and status 1 bit 0 is set. Any other first byte, including one with bit 0 = 1, is not acknowledged, sets no flag and causes no stretching.
- R3: In 10-bit mode (control bit 2 = 1), the header byte {11110, own[9:8], 0} is acknowledged without setting the address flag. A following byte equal to own[7:0] is acknowledged and sets status 1 bit 0. A mismatch on either byte is not acknowledged.
- R4: After the address acknowledge, SCL is held low (scl_pull_low = 1) while status 1 bit 0 is set, and it is released once that flag clears.
- R5: The address flag clears only when a status 1 read is followed by a status 2 read with no other register access between them. A lone status 2 read, or a status 1 read followed by some other access and then a status 2 read, leaves it set.
- R6: Each data byte is acknowledged and placed in the data register (offset 5), and status 1 bit 1 is set. Reading offset 5 clears bit 1.
- R7: If status 1 bit 1 is still set when a further byte has been fully shifted in, SCL is held low and the acknowledge is withheld until offset 5 is read. The new byte is then loaded and acknowledged.
- R8: A Stop condition after an address match sets status 1 bit 2. A Stop with no prior match leaves it clear.
- R9: The Stop flag clears only when a status 1 read is followed directly by a write to control (offset 0). A lone control write leaves it set.
- R10: With the address and Stop flags both set, performing the address sequence and then the Stop sequence, one after the other, clears both flags.
- R11: irq is 1 exactly when control bit 1 is 1 and at least one of the three status 1 flags is set.
- R12: A repeated Start restarts address matching, and a matching address sets the address flag again.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst | input | 1 | Synchronous active-high reset |
| reg_sel | input | 3 | Register offset |
| reg_rd | input | 1 | Read strobe; its side effects take place at the clock edge |
| reg_wr | input | 1 | Write strobe |
| reg_wdata | input | 8 | Write data |
| reg_rdata | output | 8 | Read data for reg_sel, combinational |
| scl_i | input | 1 | SCL line level |
| sda_i | input | 1 | SDA line level |
| scl_pull_low | output | 1 | Drive SCL low (open-drain enable) |
| sda_pull_low | output | 1 | Drive SDA low (open-drain enable) |
| irq | output | 1 | Event interrupt |

## Verification
The address matcher is tried with a table of first bytes:
- an exact 7-bit match;
- a 7-bit address one bit off;
- the right 7-bit address with the read bit set;
- a 10-bit header with the wrong high bits;
- a correct 10-bit header followed by a wrong low byte;
- a full 10-bit match.

Together these separate the compare on the address bits, the direction bit check and the two-stage 10-bit decision. Each matching case then carries a data byte and a Stop, so the acknowledge, flag and stretch paths are seen in both addressing modes.

Directed sequences cover the remaining behaviour:
- broken clear sequences, separating sequence-ordered clearing from clearing on any access;
- a second byte arriving against a full data register, showing the withheld acknowledge;
- a repeated Start;
- address and Stop flags pending together;
- the interrupt enable gating.

// File: rtl/i2c_rx_pkg.sv
`timescale 1ns/1ps
package i2c_rx_pkg;

    localparam int BYTE_W  = 8;
    localparam int REG_AW  = 3;
    localparam int OWN_W   = 10;
    localparam int CNT_W   = $clog2(BYTE_W + 1);

    typedef enum logic [REG_AW-1:0] {
        RA_CTRL  = 3'd0,
        RA_ALO   = 3'd1,
        RA_AHI   = 3'd2,
        RA_STAT1 = 3'd3,
        RA_STAT2 = 3'd4,
        RA_DATA  = 3'd5
    } reg_addr_e;

    typedef struct packed {
        logic ten;
        logic ie;
        logic en;
    } ctrl_t;

    typedef struct packed {
        logic stop;
        logic rxne;
        logic addr;
    } flags_t;

    typedef struct packed {
        logic set_addr;
        logic set_stop;
        logic load;
    } rx_evt_t;

    typedef enum logic [2:0] {
        ST_IDLE,
        ST_SHIFT,
        ST_BYTE_END,
        ST_ACK,
        ST_HOLD_ADDR,
        ST_HOLD_DATA
    } rx_state_e;

    typedef enum logic [1:0] {
        BK_ADDR7,
        BK_HDR10,
        BK_ADDR10,
        BK_DATA
    } byte_kind_e;

    function automatic logic match7(input logic [BYTE_W-1:0] b, input logic [6:0] own);
        return (b[7:1] == own) && !b[0];
    endfunction

    function automatic logic match_hdr(input logic [BYTE_W-1:0] b, input logic [1:0] hi);
        return (b[7:3] == 5'b11110) && (b[2:1] == hi) && !b[0];
    endfunction

endpackage

// File: rtl/i2c_rx_sync.sv
`timescale 1ns/1ps
module i2c_rx_sync #(
    parameter int STAGES = 2
) (
    input  logic clk,
    input  logic rst,
    input  logic scl_i,
    input  logic sda_i,
    output logic sda_s,
    output logic scl_rise,
    output logic scl_fall,
    output logic start_det,
    output logic stop_det
);
    logic [STAGES-1:0] scl_ff;
    logic [STAGES-1:0] sda_ff;
    logic              scl_q;
    logic              sda_q;
    logic              scl_s;

    // Synchronizer chain: stage 0 takes the pin, each later stage the one before.
    for (genvar g = 0; g < STAGES; g++) begin : g_stage
        always_ff @(posedge clk) begin
            if (rst) begin
                scl_ff[g] <= 1'b1;
                sda_ff[g] <= 1'b1;
            end else if (g == 0) begin
                scl_ff[g] <= scl_i;
                sda_ff[g] <= sda_i;
            end else begin
                scl_ff[g] <= scl_ff[(g == 0) ? 0 : g-1];
                sda_ff[g] <= sda_ff[(g == 0) ? 0 : g-1];
            end
        end
    end

    assign scl_s = scl_ff[STAGES-1];
    assign sda_s = sda_ff[STAGES-1];

    always_ff @(posedge clk) begin
        if (rst) begin
            scl_q <= 1'b1;
            sda_q <= 1'b1;
        end else begin
            scl_q <= scl_s;
            sda_q <= sda_s;
        end
    end

    assign scl_rise  =  scl_s && !scl_q;
    assign scl_fall  = !scl_s &&  scl_q;
    assign start_det =  scl_s &&  scl_q &&  sda_q && !sda_s;
    assign stop_det  =  scl_s &&  scl_q && !sda_q &&  sda_s;

endmodule

// File: rtl/i2c_rx_engine.sv
`timescale 1ns/1ps
module i2c_rx_engine
    import i2c_rx_pkg::*;
(
    input  logic              clk,
    input  logic              rst,
    input  logic              en,
    input  logic              ten,
    input  logic [OWN_W-1:0]  own,
    input  logic              addr_pending,
    input  logic              rxne_pending,
    input  logic              sda_s,
    input  logic              scl_rise,
    input  logic              scl_fall,
    input  logic              start_det,
    input  logic              stop_det,
    output rx_evt_t           evt,
    output logic [BYTE_W-1:0] rx_byte,
    output logic              scl_hold,
    output logic              sda_hold,
    output logic              addressed
);
    rx_state_e         st;
    byte_kind_e        kind;
    logic [CNT_W-1:0]  bitcnt;
    logic [BYTE_W-1:0] sreg;
    logic              addr_done;

    always_ff @(posedge clk) begin
        if (rst) begin
            st        <= ST_IDLE;
            kind      <= BK_ADDR7;
            bitcnt    <= '0;
            sreg      <= '0;
            addr_done <= 1'b0;
            addressed <= 1'b0;
            evt       <= '0;
        end else begin
            evt <= '0;
            if (!en) begin
                st        <= ST_IDLE;
                addressed <= 1'b0;
            end else if (stop_det) begin
                if (addressed) evt.set_stop <= 1'b1;
                addressed <= 1'b0;
                st        <= ST_IDLE;
            end else if (start_det) begin
                st        <= ST_SHIFT;
                bitcnt    <= '0;
                addr_done <= 1'b0;
                kind      <= ten ? BK_HDR10 : BK_ADDR7;
            end else begin
                case (st)
                    ST_SHIFT: if (scl_rise) begin
                        sreg   <= {sreg[BYTE_W-2:0], sda_s};
                        bitcnt <= bitcnt + 1'b1;
                        if (bitcnt == CNT_W'(BYTE_W-1)) st <= ST_BYTE_END;
                    end
                    ST_BYTE_END: if (scl_fall) begin
                        bitcnt    <= '0;
                        addr_done <= 1'b0;
                        case (kind)
                            BK_ADDR7: begin
                                if (match7(sreg, own[6:0])) begin
                                    st           <= ST_ACK;
                                    evt.set_addr <= 1'b1;
                                    addressed    <= 1'b1;
                                    addr_done    <= 1'b1;
                                    kind         <= BK_DATA;
                                end else begin
                                    st <= ST_IDLE;
                                end
                            end
                            BK_HDR10: begin
                                if (match_hdr(sreg, own[9:8])) begin
                                    st   <= ST_ACK;
                                    kind <= BK_ADDR10;
                                end else begin
                                    st <= ST_IDLE;
                                end
                            end
                            BK_ADDR10: begin
                                if (sreg == own[7:0]) begin
                                    st           <= ST_ACK;
                                    evt.set_addr <= 1'b1;
                                    addressed    <= 1'b1;
                                    addr_done    <= 1'b1;
                                    kind         <= BK_DATA;
                                end else begin
                                    st <= ST_IDLE;
                                end
                            end
                            BK_DATA: begin
                                if (rxne_pending) begin
                                    st <= ST_HOLD_DATA;
                                end else begin
                                    st       <= ST_ACK;
                                    evt.load <= 1'b1;
                                end
                            end
                            default: st <= ST_IDLE;
                        endcase
                    end
                    ST_ACK: if (scl_fall) begin
                        st <= (addr_done && addr_pending) ? ST_HOLD_ADDR : ST_SHIFT;
                    end
                    ST_HOLD_ADDR: if (!addr_pending) st <= ST_SHIFT;
                    ST_HOLD_DATA: if (!rxne_pending) begin
                        st       <= ST_ACK;
                        evt.load <= 1'b1;
                    end
                    default: ;
                endcase
            end
        end
    end

    assign rx_byte  = sreg;
    assign scl_hold = (st == ST_HOLD_ADDR) || (st == ST_HOLD_DATA);
    // SDA is already driven low while a full data register stalls the byte,
    // so releasing SCL never coincides with an SDA edge.
    assign sda_hold = (st == ST_ACK) || (st == ST_HOLD_DATA);

endmodule

// File: rtl/i2c_rx_regs.sv
`timescale 1ns/1ps
module i2c_rx_regs
    import i2c_rx_pkg::*;
(
    input  logic              clk,
    input  logic              rst,
    input  logic [REG_AW-1:0] reg_sel,
    input  logic              reg_rd,
    input  logic              reg_wr,
    input  logic [BYTE_W-1:0] reg_wdata,
    output logic [BYTE_W-1:0] reg_rdata,
    input  rx_evt_t           evt,
    input  logic [BYTE_W-1:0] rx_byte,
    input  logic              addressed,
    output ctrl_t             ctrl,
    output logic [OWN_W-1:0]  own,
    output flags_t            flags
);
    logic [BYTE_W-1:0] data_q;
    logic              armed;
    logic              snap_addr;
    logic              snap_stop;
    logic              rd_stat1;
    logic              clr_addr;
    logic              clr_stop;
    logic              clr_rxne;

    assign rd_stat1 = reg_rd && (reg_sel == RA_STAT1);
    assign clr_addr = reg_rd && (reg_sel == RA_STAT2) && armed && snap_addr;
    assign clr_stop = reg_wr && (reg_sel == RA_CTRL)  && armed && snap_stop;
    assign clr_rxne = reg_rd && (reg_sel == RA_DATA);

    always_ff @(posedge clk) begin
        if (rst) begin
            ctrl      <= '0;
            own       <= '0;
            flags     <= '0;
            data_q    <= '0;
            armed     <= 1'b0;
            snap_addr <= 1'b0;
            snap_stop <= 1'b0;
        end else begin
            if (rd_stat1) begin
                armed     <= 1'b1;
                snap_addr <= flags.addr;
                snap_stop <= flags.stop;
            end else if (reg_rd || reg_wr) begin
                armed <= 1'b0;
            end

            if (reg_wr) begin
                case (reg_sel)
                    RA_CTRL: ctrl      <= ctrl_t'(reg_wdata[2:0]);
                    RA_ALO:  own[7:0]  <= reg_wdata;
                    RA_AHI:  own[9:8]  <= reg_wdata[1:0];
                    default: ;
                endcase
            end

            // New events take priority over a clear in the same cycle.
            flags.addr <= evt.set_addr || (flags.addr && !clr_addr);
            flags.stop <= evt.set_stop || (flags.stop && !clr_stop);
            flags.rxne <= evt.load     || (flags.rxne && !clr_rxne);
            if (evt.load) data_q <= rx_byte;
        end
    end

    always_comb begin
        case (reg_sel)
            RA_CTRL:  reg_rdata = {5'b0, ctrl};
            RA_ALO:   reg_rdata = own[7:0];
            RA_AHI:   reg_rdata = {6'b0, own[9:8]};
            RA_STAT1: reg_rdata = {5'b0, flags};
            RA_STAT2: reg_rdata = {7'b0, addressed};
            RA_DATA:  reg_rdata = data_q;
            default:  reg_rdata = '0;
        endcase
    end

endmodule

// File: rtl/i2c_rx_target.sv
`timescale 1ns/1ps
module i2c_rx_target
    import i2c_rx_pkg::*;
#(
    parameter int SYNC_STAGES = 2
) (
    input  logic              clk,
    input  logic              rst,
    input  logic [REG_AW-1:0] reg_sel,
    input  logic              reg_rd,
    input  logic              reg_wr,
    input  logic [BYTE_W-1:0] reg_wdata,
    output logic [BYTE_W-1:0] reg_rdata,
    input  logic              scl_i,
    input  logic              sda_i,
    output logic              scl_pull_low,
    output logic              sda_pull_low,
    output logic              irq
);
    logic              sda_s;
    logic              scl_rise;
    logic              scl_fall;
    logic              start_det;
    logic              stop_det;
    rx_evt_t           evt;
    logic [BYTE_W-1:0] rx_byte;
    logic              addressed;
    ctrl_t             ctrl;
    logic [OWN_W-1:0]  own;
    flags_t            flags;

    i2c_rx_sync #(.STAGES(SYNC_STAGES)) sync_i (
        .clk       (clk),
        .rst       (rst),
        .scl_i     (scl_i),
        .sda_i     (sda_i),
        .sda_s     (sda_s),
        .scl_rise  (scl_rise),
        .scl_fall  (scl_fall),
        .start_det (start_det),
        .stop_det  (stop_det)
    );

    i2c_rx_engine engine_i (
        .clk          (clk),
        .rst          (rst),
        .en           (ctrl.en),
        .ten          (ctrl.ten),
        .own          (own),
        .addr_pending (flags.addr),
        .rxne_pending (flags.rxne),
        .sda_s        (sda_s),
        .scl_rise     (scl_rise),
        .scl_fall     (scl_fall),
        .start_det    (start_det),
        .stop_det     (stop_det),
        .evt          (evt),
        .rx_byte      (rx_byte),
        .scl_hold     (scl_pull_low),
        .sda_hold     (sda_pull_low),
        .addressed    (addressed)
    );

    i2c_rx_regs regs_i (
        .clk       (clk),
        .rst       (rst),
        .reg_sel   (reg_sel),
        .reg_rd    (reg_rd),
        .reg_wr    (reg_wr),
        .reg_wdata (reg_wdata),
        .reg_rdata (reg_rdata),
        .evt       (evt),
        .rx_byte   (rx_byte),
        .addressed (addressed),
        .ctrl      (ctrl),
        .own       (own),
        .flags     (flags)
    );

    assign irq = ctrl.ie && (flags != '0);

endmodule

// File: rtl/i2c_rx_target_chk.sv
`timescale 1ns/1ps
module i2c_rx_target_chk
    import i2c_rx_pkg::*;
(
    input logic              clk,
    input logic              rst,
    input logic              scl_i,
    input logic              scl_pull_low,
    input logic              sda_pull_low,
    input logic              reg_rd,
    input logic              reg_wr,
    input logic [REG_AW-1:0] reg_sel,
    input logic [2:0]        flags
);
    // Stretching is only ever caused by a pending address or data flag (R4, R7).
    assert_stretch_cause_R4: assert property (@(posedge clk) disable iff (rst)
        scl_pull_low |-> $past(flags[0] || flags[1]));

    // The address flag survives every cycle without a status 2 read (R5).
    assert_addr_hold_R5: assert property (@(posedge clk) disable iff (rst)
        (flags[0] && !(reg_rd && reg_sel == RA_STAT2)) |=> flags[0]);

    // The data flag survives every cycle without a data read (R6).
    assert_rxne_hold_R6: assert property (@(posedge clk) disable iff (rst)
        (flags[1] && !(reg_rd && reg_sel == RA_DATA)) |=> flags[1]);

    // The acknowledge drive only starts while SCL is low (R6).
    assert_ack_scl_low_R6: assert property (@(posedge clk) disable iff (rst)
        $rose(sda_pull_low) |-> !scl_i);

    // The Stop flag survives every cycle without a control write (R9).
    assert_stop_hold_R9: assert property (@(posedge clk) disable iff (rst)
        (flags[2] && !(reg_wr && reg_sel == RA_CTRL)) |=> flags[2]);

endmodule

bind i2c_rx_target i2c_rx_target_chk chk_i (
    .clk          (clk),
    .rst          (rst),
    .scl_i        (scl_i),
    .scl_pull_low (scl_pull_low),
    .sda_pull_low (sda_pull_low),
    .reg_rd       (reg_rd),
    .reg_wr       (reg_wr),
    .reg_sel      (reg_sel),
    .flags        (flags)
);

// File: tb/i2c_rx_target_tb_top.sv
`timescale 1ns/1ps
module i2c_rx_target_tb_top;
    localparam int Q = 10;

    localparam logic [2:0] A_CTRL  = 3'd0;
    localparam logic [2:0] A_ALO   = 3'd1;
    localparam logic [2:0] A_AHI   = 3'd2;
    localparam logic [2:0] A_STAT1 = 3'd3;
    localparam logic [2:0] A_STAT2 = 3'd4;
    localparam logic [2:0] A_DATA  = 3'd5;

    logic       clk = 1'b0;
    logic       rst = 1'b1;
    logic [2:0] reg_sel = '0;
    logic       reg_rd = 1'b0;
    logic       reg_wr = 1'b0;
    logic [7:0] reg_wdata = '0;
    logic [7:0] reg_rdata;
    logic       m_scl = 1'b1;
    logic       m_sda = 1'b1;
    logic       scl_line;
    logic       sda_line;
    logic       scl_pull_low;
    logic       sda_pull_low;
    logic       irq;

    int n_chk = 0;
    int n_err = 0;

    always #2 clk = ~clk;

    assign scl_line = m_scl && !scl_pull_low;
    assign sda_line = m_sda && !sda_pull_low;

    i2c_rx_target dut_i (
        .clk          (clk),
        .rst          (rst),
        .reg_sel      (reg_sel),
        .reg_rd       (reg_rd),
        .reg_wr       (reg_wr),
        .reg_wdata    (reg_wdata),
        .reg_rdata    (reg_rdata),
        .scl_i        (scl_line),
        .sda_i        (sda_line),
        .scl_pull_low (scl_pull_low),
        .sda_pull_low (sda_pull_low),
        .irq          (irq)
    );

    typedef struct packed {
        logic       ten;
        logic [9:0] own;
        logic [7:0] b0;
        logic [7:0] b1;
        logic       hdr_ack;
        logic       match;
        logic [7:0] data;
    } vec_t;

    localparam vec_t VECS [0:5] = '{
        vec_t'({1'b0, 10'h03A, 8'h74, 8'h00, 1'b0, 1'b1, 8'hA5}),
        vec_t'({1'b0, 10'h03A, 8'h76, 8'h00, 1'b0, 1'b0, 8'h00}),
        vec_t'({1'b0, 10'h03A, 8'h75, 8'h00, 1'b0, 1'b0, 8'h00}),
        vec_t'({1'b1, 10'h2C5, 8'hF4, 8'hC5, 1'b1, 1'b1, 8'h3C}),
        vec_t'({1'b1, 10'h2C5, 8'hF2, 8'hC5, 1'b0, 1'b0, 8'h00}),
        vec_t'({1'b1, 10'h2C5, 8'hF4, 8'hC6, 1'b1, 1'b0, 8'h00})
    };

    task automatic chk(input string tag, input logic [31:0] act, input logic [31:0] exp);
        n_chk++;
        if (act !== exp) begin
            n_err++;
            $display("FAIL %s: actual=%0h expected=%0h", tag, act, exp);
        end
    endtask

    task automatic wait_cyc(input int n);
        repeat (n) @(negedge clk);
    endtask

    task automatic cpu_rd(input logic [2:0] sel, output logic [7:0] d);
        @(negedge clk);
        reg_sel = sel;
        reg_rd  = 1'b1;
        #1;
        d = reg_rdata;
        @(negedge clk);
        reg_rd = 1'b0;
    endtask

    task automatic cpu_wr(input logic [2:0] sel, input logic [7:0] d);
        @(negedge clk);
        reg_sel   = sel;
        reg_wdata = d;
        reg_wr    = 1'b1;
        @(negedge clk);
        reg_wr = 1'b0;
    endtask

    task automatic scl_up();
        m_scl = 1'b1;
        @(negedge clk);
        while (scl_line == 1'b0) @(negedge clk);
        wait_cyc(Q);
    endtask

    task automatic bus_start();
        m_sda = 1'b1; wait_cyc(Q);
        scl_up();
        m_sda = 1'b0; wait_cyc(Q);
        m_scl = 1'b0; wait_cyc(Q);
    endtask

    task automatic bus_stop();
        m_sda = 1'b0; wait_cyc(Q);
        scl_up();
        m_sda = 1'b1; wait_cyc(Q);
    endtask

    task automatic send_byte(input logic [7:0] b, output logic ack);
        for (int i = 7; i >= 0; i--) begin
            m_sda = b[i]; wait_cyc(Q);
            scl_up();
            m_scl = 1'b0; wait_cyc(Q);
        end
        m_sda = 1'b1; wait_cyc(Q);
        scl_up();
        ack = !sda_line;
        m_scl = 1'b0; wait_cyc(Q);
    endtask

    initial begin
        repeat (150000) @(posedge clk);
        n_err++;
        n_chk++;
        $display("FAIL watchdog (all requirements): actual=timeout expected=completion");
        $display("Result: errors=%0d of %0d checks", n_err, n_chk);
        $finish;
    end

    initial begin
        logic [7:0] d;
        logic       ack;
        logic       ack2;

        wait_cyc(5);
        rst = 1'b0;
        wait_cyc(3);
        // R1: reset state
        chk("R1 scl_pull_low", scl_pull_low, 0);
        chk("R1 sda_pull_low", sda_pull_low, 0);
        chk("R1 irq", irq, 0);
        cpu_rd(A_STAT1, d);
        chk("R1 status1", d, 0);

        // Vector table: address matching in both modes
        for (int i = 0; i < 6; i++) begin
            vec_t v;
            string atag;
            v = VECS[i];
            atag = v.ten ? "R3 address ack" : "R2 address ack";
            cpu_wr(A_ALO, v.own[7:0]);
            cpu_wr(A_AHI, {6'b0, v.own[9:8]});
            cpu_wr(A_CTRL, {5'b0, v.ten, 1'b1, 1'b1});
            bus_start();
            send_byte(v.b0, ack);
            if (v.ten) begin
                chk("R3 header ack", ack, v.hdr_ack);
                if (ack) begin
                    cpu_rd(A_STAT1, d);
                    chk("R3 no flag after header", d[0], 0);
                    send_byte(v.b1, ack);
                end
            end
            chk(atag, ack, v.match);
            wait_cyc(8);
            if (v.match) begin
                chk("R4 stretch on address", scl_pull_low, 1);
                chk("R11 irq on address", irq, 1);
                cpu_rd(A_STAT1, d);
                chk("R2 address flag", d[0], 1);
                cpu_rd(A_STAT2, d);
                wait_cyc(2);
                chk("R4 stretch released", scl_pull_low, 0);
                cpu_rd(A_STAT1, d);
                chk("R5 address flag cleared", d[0], 0);
                send_byte(v.data, ack);
                chk("R6 data ack", ack, 1);
                wait_cyc(4);
                cpu_rd(A_STAT1, d);
                chk("R6 rxne set", d[1], 1);
                cpu_rd(A_DATA, d);
                chk("R6 data value", d, v.data);
                cpu_rd(A_STAT1, d);
                chk("R6 rxne cleared", d[1], 0);
            end else begin
                chk("R2 no stretch on mismatch", scl_pull_low, 0);
                cpu_rd(A_STAT1, d);
                chk("R2 no flag on mismatch", d, 0);
            end
            bus_stop();
            wait_cyc(8);
            cpu_rd(A_STAT1, d);
            chk("R8 stop flag", d[2], v.match);
            if (v.match) begin
                cpu_wr(A_CTRL, {5'b0, v.ten, 1'b1, 1'b1});
                cpu_rd(A_STAT1, d);
                chk("R9 stop cleared", d, 0);
            end
        end

        // R5: broken clear sequences
        cpu_wr(A_ALO, 8'h3A);
        cpu_wr(A_CTRL, 8'h03);
        bus_start();
        send_byte(8'h74, ack);
        wait_cyc(8);
        cpu_rd(A_STAT2, d);
        wait_cyc(2);
        chk("R5 lone status2 read keeps stretch", scl_pull_low, 1);
        chk("R5 lone status2 read keeps irq", irq, 1);
        cpu_rd(A_STAT1, d);
        cpu_rd(A_DATA, d);
        cpu_rd(A_STAT2, d);
        wait_cyc(2);
        chk("R5 interrupted sequence keeps stretch", scl_pull_low, 1);
        cpu_rd(A_STAT1, d);
        cpu_rd(A_STAT2, d);
        wait_cyc(2);
        chk("R5 proper sequence releases", scl_pull_low, 0);

        // R7: second byte against a full data register
        send_byte(8'h11, ack);
        chk("R6 first data ack", ack, 1);
        fork
            send_byte(8'h22, ack2);
            begin
                while (scl_pull_low == 1'b0) @(negedge clk);
                wait_cyc(30);
                chk("R7 stretch while full", scl_pull_low, 1);
                chk("R7 master stalled", scl_line, 0);
                cpu_rd(A_DATA, d);
                chk("R7 first byte kept", d, 8'h11);
            end
        join
        chk("R7 ack after read", ack2, 1);
        wait_cyc(4);
        cpu_rd(A_DATA, d);
        chk("R7 second byte loaded", d, 8'h22);

        // R12: repeated start
        bus_start();
        send_byte(8'h74, ack);
        chk("R12 repeated start ack", ack, 1);
        wait_cyc(8);
        chk("R12 address flag again", scl_pull_low, 1);
        cpu_rd(A_STAT1, d);
        cpu_rd(A_STAT2, d);
        bus_stop();
        wait_cyc(8);

        // R10: both flags pending
        bus_start();
        send_byte(8'h74, ack);
        wait_cyc(8);
        cpu_rd(A_STAT1, d);
        chk("R10 both pending", d, 8'h05);
        cpu_rd(A_STAT1, d);
        cpu_rd(A_STAT2, d);
        cpu_rd(A_STAT1, d);
        cpu_wr(A_CTRL, 8'h03);
        cpu_rd(A_STAT1, d);
        chk("R10 both cleared", d, 0);
        chk("R10 stretch released", scl_pull_low, 0);
        bus_stop();
        wait_cyc(8);

        // R9 and R11: lone control writes, interrupt gating
        cpu_rd(A_STAT2, d);
        cpu_wr(A_CTRL, 8'h01);
        chk("R11 irq masked", irq, 0);
        cpu_rd(A_STAT2, d);
        cpu_wr(A_CTRL, 8'h03);
        chk("R11 irq with stop pending", irq, 1);
        cpu_rd(A_STAT1, d);
        chk("R9 lone write keeps stop", d[2], 1);
        cpu_wr(A_CTRL, 8'h03);
        cpu_rd(A_STAT1, d);
        chk("R9 sequence clears stop", d, 0);
        chk("R11 irq low when clear", irq, 0);

        $display("Result: errors=%0d of %0d checks", n_err, n_chk);
        $finish;
    end

endmodule